// File: doc/BRIEF.md
# I/O Address Activity Monitor

This block watches the I/O strobes of a peripheral bus. It reports when a cycle reaches either of two programmable 8-byte address windows, and that report is what power-management software uses to spot device activity. Software sets each channel's window through a write-only address register, which holds I/O address bits 9..3. A shared enable register turns each channel on. A shared status register records hits, and each hit stays recorded until software writes a one to that bit. The block also gives a one-cycle activity pulse to an external idle timer each time an enabled channel starts a new run of hits.

All pins are plain control and status signals. The block has no data stream, so it has no valid/ready handshake. Configuration writes take effect on the clock edge that samples them. A bus cycle on that same edge is compared against the values held before the write.

Top module: `io_activity_mon`

## Requirements
- R1: After reset, every register holds 0. `act_stat` reads 0x00 and `act_pulse` is 0, and no bus cycle counts as a hit until a channel is enabled.
- R2: A write with `cfg_sel`=0 loads the channel 0 window and a write with `cfg_sel`=1 loads the channel 1 window. In both cases `cfg_wdata[6:0]` is taken as I/O address bits 9..3, and `cfg_wdata[7]` is reserved and has no effect.
- R3: A channel hits in a cycle when `io_rd` or `io_wr` is 1 and `io_addr[9:3]` equals its window. `io_addr[2:0]` plays no part in the match.
- R4: A write with `cfg_sel`=2 loads the enable register. `cfg_wdata[4]`=1 enables channel 0, `cfg_wdata[5]`=1 enables channel 1, and the other bits have no effect.
- R5: A hit on channel 0 sets `act_stat[4]` and a hit on channel 1 sets `act_stat[5]`. The bit is visible from the clock edge that sampled the hit onward. All other `act_stat` bits always read 0.
- R6: Status bits are sticky. A write with `cfg_sel`=3 clears each status bit that has a 1 in the same position of `cfg_wdata`, and a 0 in a position leaves that bit unchanged.
- R7: When a hit and a clear of the same status bit fall in the same cycle, the bit ends set.
- R8: `act_pulse` is 1 for exactly one cycle after the first cycle of each run of consecutive hit cycles on any enabled channel. A strobe held on the window gives one pulse, and a new run gives a new pulse.
- R9: A disabled channel neither sets its status bit nor causes a pulse, even while its window matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 window 0, 1 window 1, 2 enable, 3 status clear |
| cfg_wdata | input | 8 | Configuration write data |
| io_addr | input | 10 | I/O bus address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| act_stat | output | 8 | Status register, channel 0 in bit 4, channel 1 in bit 5 |
| act_pulse | output | 1 | One-cycle activity event |

## Verification
Bus cycles are driven in several forms, each aimed at a different fault:
- Read-only, write-only and both-strobe cycles, which separate a design that ORs the strobes from one that watches only one of them.
- Addresses that walk the low three bits inside a window, or step just past its edge, which show whether the window is 8-byte aligned.
- Strobes held over several cycles, and runs that hop straight from one channel to the other, which separate first-cycle detection from plain level reporting.
- Clear writes that land with or without a hit in the same cycle, and enable writes that carry stray bits, which test the sticky and priority rules and the exact enable bit positions.

// File: rtl/iom_pkg.sv
package iom_pkg;
  localparam int REG_W     = 8;
  localparam int IO_AW     = 10;
  localparam int MATCH_LSB = 3;
  localparam int MATCH_W   = IO_AW - MATCH_LSB;
  localparam int NUM_CH    = 2;
  localparam int BIT_BASE  = 4;

  typedef enum logic [1:0] {
    SEL_WIN0  = 2'd0,
    SEL_WIN1  = 2'd1,
    SEL_EN    = 2'd2,
    SEL_CLEAR = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/iom_cfg_regs.sv
module iom_cfg_regs #(
  parameter int NUM_CH   = 2,
  parameter int MATCH_W  = 7,
  parameter int REG_W    = 8,
  parameter int BIT_BASE = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_sel,
  input  logic [REG_W-1:0]       cfg_wdata,
  output logic [MATCH_W-1:0]     win_q [NUM_CH],
  output logic [NUM_CH-1:0]      en_q,
  output logic [NUM_CH-1:0]      clr_req
);
  import iom_pkg::*;

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n)
        win_q[g] <= '0;
      else if (cfg_we && cfg_sel == 2'(g))
        win_q[g] <= cfg_wdata[MATCH_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      en_q <= '0;
    else if (cfg_we && cfg_sel == SEL_EN)
      en_q <= cfg_wdata[BIT_BASE +: NUM_CH];
  end

  always_comb begin
    clr_req = '0;
    if (cfg_we && cfg_sel == SEL_CLEAR)
      clr_req = cfg_wdata[BIT_BASE +: NUM_CH];
  end
endmodule

// File: rtl/iom_match_chan.sv
module iom_match_chan #(
  parameter int IO_AW     = 10,
  parameter int MATCH_LSB = 3,
  localparam int MATCH_W  = IO_AW - MATCH_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IO_AW-1:0]   io_addr,
  input  logic               strobe,
  input  logic [MATCH_W-1:0] win,
  input  logic               en,
  output logic               hit,
  output logic               first
);
  logic hit_d;
  logic unused_low;
  assign unused_low = ^io_addr[MATCH_LSB-1:0];

  assign hit   = en && strobe && (io_addr[IO_AW-1:MATCH_LSB] == win);
  assign first = hit && !hit_d;

  always_ff @(posedge clk) begin
    if (!rst_n) hit_d <= 1'b0;
    else        hit_d <= hit;
  end
endmodule

// File: rtl/iom_status.sv
module iom_status #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_req,
  input  logic [NUM_CH-1:0] clr_req,
  output logic [NUM_CH-1:0] st_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr_req) | set_req;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R6
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_q[g]) |-> $past(clr_req[g]));
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(set_req[g]) |-> st_q[g]);
  end
endmodule

// File: rtl/io_activity_mon.sv
module io_activity_mon (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_sel,
  input  logic [7:0] cfg_wdata,
  input  logic [9:0] io_addr,
  input  logic       io_rd,
  input  logic       io_wr,
  output logic [7:0] act_stat,
  output logic       act_pulse
);
  import iom_pkg::*;

  logic [MATCH_W-1:0] win_q [NUM_CH];
  logic [NUM_CH-1:0]  en_q, clr_req, hit, first, st_q;
  logic               strobe, pulse_q;

  assign strobe = io_rd | io_wr;

  iom_cfg_regs #(
    .NUM_CH(NUM_CH), .MATCH_W(MATCH_W), .REG_W(REG_W), .BIT_BASE(BIT_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .win_q(win_q), .en_q(en_q), .clr_req(clr_req)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    iom_match_chan #(.IO_AW(IO_AW), .MATCH_LSB(MATCH_LSB)) u_chan (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .strobe(strobe),
      .win(win_q[g]), .en(en_q[g]), .hit(hit[g]), .first(first[g])
    );
    // R5
    rise_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_stat[BIT_BASE+g]) |-> $past(hit[g]));
  end

  iom_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_req(hit), .clr_req(clr_req), .st_q(st_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= |first;
  end
  assign act_pulse = pulse_q;

  always_comb begin
    act_stat = '0;
    act_stat[BIT_BASE +: NUM_CH] = st_q;
  end

  // R8
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |-> $past(|hit));
  // R5
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_stat) == $countones(act_stat[BIT_BASE +: NUM_CH]));
endmodule

// File: tb/io_activity_mon_bench.sv
module io_activity_mon_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [9:0] io_addr = 10'h000;
  logic       io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] act_stat;
  logic       act_pulse;

  always #5 clk = ~clk;

  io_activity_mon u_io_activity_mon (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .act_stat(act_stat), .act_pulse(act_pulse)
  );

  int total = 0, bad = 0;
  int m_win [2];
  bit m_en [2];
  bit m_st [2];
  bit m_prev [2];
  bit m_pulse;
  string cur_req = "R1";

  task automatic check_now();
    logic [7:0] es;
    es = 8'h00;
    es[4] = m_st[0];
    es[5] = m_st[1];
    total++;
    if (act_stat !== es) begin
      bad++;
      $display("FAIL %s act_stat actual=%02h expected=%02h t=%0t", cur_req, act_stat, es, $time);
    end
    total++;
    if (act_pulse !== m_pulse) begin
      bad++;
      $display("FAIL %s act_pulse actual=%0b expected=%0b t=%0t", cur_req, act_pulse, m_pulse, $time);
    end
  endtask

  task automatic cyc(string req, bit we, int sel, int wd, int addr, bit rd, bit wr);
    bit h [2];
    bit any_first;
    cur_req = req;
    cfg_we = we; cfg_sel = 2'(sel); cfg_wdata = 8'(wd);
    io_addr = 10'(addr); io_rd = rd; io_wr = wr;
    any_first = 0;
    for (int k = 0; k < 2; k++) begin
      h[k] = m_en[k] && (rd || wr) && (((addr >> 3) & 8'h7f) == m_win[k]);
      if (h[k] && !m_prev[k]) any_first = 1;
    end
    for (int k = 0; k < 2; k++) begin
      bit clr;
      clr = we && sel == 3 && wd[4+k];
      m_st[k] = (m_st[k] && !clr) || h[k];
      m_prev[k] = h[k];
    end
    m_pulse = any_first;
    if (we && sel < 2) m_win[sel] = wd & 8'h7f;
    if (we && sel == 2) begin m_en[0] = wd[4]; m_en[1] = wd[5]; end
    @(negedge clk);
    check_now();
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) cyc(req, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin m_win[k] = 0; m_en[k] = 0; m_st[k] = 0; m_prev[k] = 0; end
    m_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    check_now();
    // R1: window 0 matches reset value but channels are off
    cyc("R1", 0, 0, 0, 10'h000, 1, 0);
    cyc("R1", 0, 0, 0, 10'h005, 0, 1);
    idle("R1", 1);
    // R2: program windows, reserved bit 7 set
    cyc("R2", 1, 0, 8'hAA, 0, 0, 0);   // window 0 -> 0x150..0x157
    cyc("R2", 1, 1, 8'h11, 0, 0, 0);   // window 1 -> 0x088..0x08F
    // R9: disabled channels ignore matching cycles
    cyc("R9", 0, 0, 0, 10'h150, 1, 0);
    cyc("R9", 0, 0, 0, 10'h088, 0, 1);
    idle("R9", 1);
    // R4: enable only channel 0
    cyc("R4", 1, 2, 8'h10, 0, 0, 0);
    cyc("R9", 0, 0, 0, 10'h08C, 1, 0);
    idle("R9", 1);
    // R3: read, write, both, low bits vary, edges of window
    cyc("R3", 0, 0, 0, 10'h14F, 1, 0);
    cyc("R3", 0, 0, 0, 10'h158, 0, 1);
    cyc("R3", 0, 0, 0, 10'h157, 1, 0);
    idle("R3", 1);
    cyc("R6", 1, 3, 8'h10, 0, 0, 0);
    cyc("R3", 0, 0, 0, 10'h153, 0, 1);
    idle("R3", 1);
    cyc("R6", 1, 3, 8'h10, 0, 0, 0);
    cyc("R3", 0, 0, 0, 10'h150, 1, 1);
    cyc("R3", 0, 0, 0, 10'h150, 0, 0);
    // R6: zero write keeps, one write clears
    cyc("R6", 1, 3, 8'hEF, 0, 0, 0);
    idle("R6", 1);
    cyc("R6", 1, 3, 8'h10, 0, 0, 0);
    idle("R6", 1);
    // R8: held strobe gives one pulse
    for (int i = 0; i < 4; i++) cyc("R8", 0, 0, 0, 10'h150 + i, 1, 0);
    idle("R8", 1);
    cyc("R8", 0, 0, 0, 10'h156, 0, 1);
    cyc("R8", 0, 0, 0, 10'h156, 0, 1);
    // R7: clear and hit in same cycle
    cyc("R7", 1, 3, 8'h30, 10'h151, 1, 0);
    idle("R7", 1);
    cyc("R7", 1, 3, 8'h30, 0, 0, 0);
    // R5: enable both; channel 1 lands in bit 5
    cyc("R5", 1, 2, 8'h30, 0, 0, 0);
    cyc("R5", 0, 0, 0, 10'h08F, 0, 1);
    cyc("R5", 0, 0, 0, 10'h08F, 0, 0);
    // R8: hopping runs between channels
    cyc("R8", 0, 0, 0, 10'h150, 1, 0);
    cyc("R8", 0, 0, 0, 10'h088, 1, 0);
    cyc("R8", 0, 0, 0, 10'h150, 1, 0);
    cyc("R8", 0, 0, 0, 10'h152, 1, 0);
    idle("R8", 2);
    // R4: stray bits with channel bits clear disable both
    cyc("R6", 1, 3, 8'hFF, 0, 0, 0);
    cyc("R4", 1, 2, 8'hCF, 0, 0, 0);
    cyc("R4", 0, 0, 0, 10'h150, 1, 0);
    cyc("R4", 0, 0, 0, 10'h088, 0, 1);
    idle("R4", 1);
    // R2: both windows equal, channel 1 only enabled
    cyc("R2", 1, 0, 8'h11, 0, 0, 0);
    cyc("R4", 1, 2, 8'h20, 0, 0, 0);
    cyc("R2", 0, 0, 0, 10'h08A, 1, 0);
    cyc("R2", 1, 2, 8'h30, 0, 0, 0);
    cyc("R2", 0, 0, 0, 10'h089, 0, 1);
    idle("R2", 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired, requirement %s: actual=running expected=finished", cur_req);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule